// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog that sits on a small 16-bit register bus. Once software clears the halt bit, the counter steps down by one on each tick-enable pulse. The tick source is a slow timebase outside the block, nominally one pulse every 0.6 s. Software keeps the watchdog alive by writing anything to the reload register, which puts the counter back to the programmed initial value.

If software stops writing, the counter runs out. The first expiry sets a timeout flag, sends a one-cycle interrupt request and restarts the count. If the counter runs out again while the timeout flag is still set, the block sets the second-timeout and boot flags. It also sends a one-cycle system reset request, unless the no-reboot gate is set. The status flags are write-one-to-clear. Writes to the initial-value field below 4 are rejected.

All accesses are 16-bit, at even byte offsets within a 32-byte window, and each access carries two byte enables. Reads are combinational from the address.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the register values are as follows. Offset 0x00 reads 4. Offset 0x04 and offset 0x06 read 0. Offset 0x08 reads 0x0801, meaning halt and no-reboot are both 1. Offset 0x12 reads 0x0004. Both irq_o and rst_req_o are low.
- R2: While halt is 0, each tick_i pulse lowers the count by one. The current count reads back from offset 0x00 in bits [9:0].
- R3: The halt bit is bit 11 of offset 0x08 and reads back as written. While it is 1, ticks leave the count unchanged.
- R4: Any write with at least one byte enabled to offset 0x00 loads the initial value into the counter. Such a write wins over a tick in the same cycle, and that tick causes no expiry.
- R5: Offset 0x12 holds the initial value in bits [9:0]. Bits [15:10] are stored and read back as written. A write that would leave the field at 0 to 3 keeps the old field, but the upper bits still update.
- R6: A tick that finds the count at 0 while the timeout flag (offset 0x04 bit 3) is clear causes the first-stage expiry. It sets the timeout flag, raises irq_o for exactly one cycle and reloads the counter. As a result, the first expiry follows init+1 ticks after a reload.
- R7: A tick that finds the count at 0 while the timeout flag is set causes the second-stage expiry. It sets the second-timeout flag (offset 0x06 bit 1) and the boot flag (offset 0x06 bit 2). It raises rst_req_o for one cycle when no-reboot is 0, reloads the counter, leaves the timeout flag set and gives no irq_o pulse.
- R8: The no-reboot bit is bit 0 of offset 0x08 and reads back as written. While it is 1, rst_req_o stays low, but the flags in R7 are still set.
- R9: Writing 1 to a status flag bit clears that flag, and writing 0 leaves it unchanged. An expiry that sets a flag in the same cycle as a clear of that flag wins.
- R10: Byte enable be_i[0] gates bits [7:0] and be_i[1] gates bits [15:8]. A write with a byte disabled leaves the bits of that byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Byte offset of the access |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| be_i | input | 2 | Byte enables for the low and high byte |
| rdata_o | output | 16 | Read data for addr_i |
| tick_i | input | 1 | One-cycle countdown enable pulse |
| irq_o | output | 1 | One-cycle interrupt request on first expiry |
| rst_req_o | output | 1 | One-cycle system reset request on second expiry |

## Verification
The hardest case to reach is a status-flag clear that lands on the same clock edge as an expiry. A close second is a reload write that coincides with the tick that would otherwise expire the counter. The bench drives bus writes and tick pulses from a single per-cycle task, so it can put a write-one-to-clear or a reload write on exactly the tick that finds the count at zero. Around that, it sweeps several initial values, including the largest, through both expiry stages with no-reboot set in some runs and clear in others. It also sweeps the rejected initial values 0 to 3.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;

  localparam logic [ADDR_W-1:0] OFF_RELOAD = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_STS1   = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_STS2   = 5'h06;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_INIT   = 5'h12;

  localparam int unsigned TO_BIT       = 3;
  localparam int unsigned SECOND_BIT   = 1;
  localparam int unsigned BOOT_BIT     = 2;
  localparam int unsigned HALT_BIT     = 11;
  localparam int unsigned NOREBOOT_BIT = 0;

  typedef struct packed {
    logic reload;
    logic clr_to;
    logic clr_second;
    logic clr_boot;
  } wr_pulse_t;

  typedef enum logic [1:0] {
    EXP_NONE   = 2'd0,
    EXP_FIRST  = 2'd1,
    EXP_SECOND = 2'd2
  } expiry_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned MIN_INIT = 4,
  parameter int unsigned RST_INIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic [1:0]        be_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              to_flag_i,
  input  logic              second_flag_i,
  input  logic              boot_flag_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  init_o,
  output logic              halt_o,
  output logic              no_reboot_o,
  output wr_pulse_t         pulse_o
);
  localparam int unsigned HALT_BYTE = HALT_BIT / 8;
  localparam int unsigned NR_BYTE   = NOREBOOT_BIT / 8;
  localparam int unsigned TO_BYTE   = TO_BIT / 8;
  localparam int unsigned SEC_BYTE  = SECOND_BIT / 8;
  localparam int unsigned BOOT_BYTE = BOOT_BIT / 8;

  logic [DATA_W-1:0] init_q, wmask, init_merged;
  logic              halt_q, no_reboot_q;
  logic              any_be, wr_init, wr_ctrl, field_ok;

  assign any_be      = |be_i;
  assign wmask       = {{8{be_i[1]}}, {8{be_i[0]}}};
  assign init_merged = (init_q & ~wmask) | (wdata_i & wmask);
  assign field_ok    = init_merged[CNT_W-1:0] >= CNT_W'(MIN_INIT);
  assign wr_init     = we_i && any_be && (addr_i == OFF_INIT);
  assign wr_ctrl     = we_i && (addr_i == OFF_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= DATA_W'(RST_INIT);
    end else if (wr_init) begin
      init_q[DATA_W-1:CNT_W] <= init_merged[DATA_W-1:CNT_W];
      if (field_ok) init_q[CNT_W-1:0] <= init_merged[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q      <= 1'b1;
      no_reboot_q <= 1'b1;
    end else if (wr_ctrl) begin
      if (be_i[HALT_BYTE]) halt_q      <= wdata_i[HALT_BIT];
      if (be_i[NR_BYTE])   no_reboot_q <= wdata_i[NOREBOOT_BIT];
    end
  end

  always_comb begin
    pulse_o.reload     = we_i && any_be && (addr_i == OFF_RELOAD);
    pulse_o.clr_to     = we_i && (addr_i == OFF_STS1) && be_i[TO_BYTE] && wdata_i[TO_BIT];
    pulse_o.clr_second = we_i && (addr_i == OFF_STS2) && be_i[SEC_BYTE] && wdata_i[SECOND_BIT];
    pulse_o.clr_boot   = we_i && (addr_i == OFF_STS2) && be_i[BOOT_BYTE] && wdata_i[BOOT_BIT];
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_RELOAD: rdata_o = DATA_W'(cnt_i);
      OFF_STS1:   rdata_o[TO_BIT] = to_flag_i;
      OFF_STS2: begin
        rdata_o[SECOND_BIT] = second_flag_i;
        rdata_o[BOOT_BIT]   = boot_flag_i;
      end
      OFF_CTRL: begin
        rdata_o[HALT_BIT]     = halt_q;
        rdata_o[NOREBOOT_BIT] = no_reboot_q;
      end
      OFF_INIT:   rdata_o = init_q;
      default:    rdata_o = '0;
    endcase
  end

  assign init_o      = init_q[CNT_W-1:0];
  assign halt_o      = halt_q;
  assign no_reboot_o = no_reboot_q;

  assert_init_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q[CNT_W-1:0] >= CNT_W'(MIN_INIT));
  assert_ctrl_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && be_i[HALT_BYTE]) |=> (halt_o == $past(wdata_i[HALT_BIT])));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned RST_INIT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step     = tick_i && !halt_i && !reload_i;
  assign expire_o = step && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= CNT_W'(RST_INIT);
    else if (reload_i) cnt_q <= init_i;
    else if (step)     cnt_q <= (cnt_q == '0) ? init_i : cnt_q - CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  assert_reload_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (cnt_o == $past(init_i)));
  assert_halt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !reload_i) |=> $stable(cnt_o));
  assert_step_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !halt_i && !reload_i && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));
endmodule

// File: rtl/wdog_expiry.sv
module wdog_expiry
  import wdog_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic no_reboot_i,
  input  logic clr_to_i,
  input  logic clr_second_i,
  input  logic clr_boot_i,
  output logic to_o,
  output logic second_o,
  output logic boot_o,
  output logic irq_o,
  output logic rst_req_o
);
  expiry_e kind;
  logic    to_q, second_q, boot_q, irq_q, rst_q;

  always_comb begin
    if (!expire_i)  kind = EXP_NONE;
    else if (to_q)  kind = EXP_SECOND;
    else            kind = EXP_FIRST;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_q     <= 1'b0;
      second_q <= 1'b0;
      boot_q   <= 1'b0;
      irq_q    <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      // set beats a same-cycle clear
      if (kind == EXP_FIRST)       to_q     <= 1'b1;
      else if (clr_to_i)           to_q     <= 1'b0;
      if (kind == EXP_SECOND)      second_q <= 1'b1;
      else if (clr_second_i)       second_q <= 1'b0;
      if (kind == EXP_SECOND)      boot_q   <= 1'b1;
      else if (clr_boot_i)         boot_q   <= 1'b0;
      irq_q <= (kind == EXP_FIRST);
      rst_q <= (kind == EXP_SECOND) && !no_reboot_i;
    end
  end

  assign to_o      = to_q;
  assign second_o  = second_q;
  assign boot_o    = boot_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;

  assert_irq_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  assert_irq_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> to_o);
  assert_rst_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (second_o && boot_o && to_o && !irq_o));
  assert_rst_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  assert_rst_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !$past(no_reboot_i));
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned MIN_INIT = 4,
  parameter int unsigned RST_INIT = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [4:0]  addr_i,
  input  logic [15:0] wdata_i,
  input  logic        we_i,
  input  logic [1:0]  be_i,
  output logic [15:0] rdata_o,
  input  logic        tick_i,
  output logic        irq_o,
  output logic        rst_req_o
);
  logic [CNT_W-1:0] cnt, init_val;
  logic             halt, no_reboot, expire;
  logic             to_flag, second_flag, boot_flag;
  wr_pulse_t        pulse;

  wdog_regs #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT), .RST_INIT(RST_INIT)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .be_i,
    .cnt_i(cnt), .to_flag_i(to_flag), .second_flag_i(second_flag), .boot_flag_i(boot_flag),
    .rdata_o, .init_o(init_val), .halt_o(halt), .no_reboot_o(no_reboot), .pulse_o(pulse)
  );

  wdog_counter #(.CNT_W(CNT_W), .RST_INIT(RST_INIT)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .halt_i(halt), .reload_i(pulse.reload),
    .init_i(init_val), .cnt_o(cnt), .expire_o(expire)
  );

  wdog_expiry u_exp (
    .clk_i, .rst_ni, .expire_i(expire), .no_reboot_i(no_reboot),
    .clr_to_i(pulse.clr_to), .clr_second_i(pulse.clr_second), .clr_boot_i(pulse.clr_boot),
    .to_o(to_flag), .second_o(second_flag), .boot_o(boot_flag),
    .irq_o, .rst_req_o
  );
endmodule

// File: tb/tb_wdog_two_stage.sv
module tb_wdog_two_stage;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic [1:0]  be = '0;
  logic [15:0] rdata;
  logic        tick = 1'b0;
  logic        irq, rst_req;
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;
  logic [15:0] init_model;

  wdog_two_stage dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .be_i(be), .rdata_o(rdata), .tick_i(tick), .irq_o(irq), .rst_req_o(rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [4:0] a, input logic [15:0] d,
                      input logic [1:0] b, input logic t);
    we = w; addr = a; wdata = d; be = b; tick = t;
    @(posedge clk); @(negedge clk);
    we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [15:0] exp, input string req);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  function automatic logic [15:0] init_rule(input logic [15:0] old, input logic [15:0] d,
                                            input logic [1:0] b);
    logic [15:0] m, mg;
    m  = {{8{b[1]}}, {8{b[0]}}};
    mg = (old & ~m) | (d & m);
    return {mg[15:10], (mg[9:0] >= 10'd4) ? mg[9:0] : old[9:0]};
  endfunction

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk(5'h00, 16'h0004, "R1");
    rd_chk(5'h04, 16'h0000, "R1");
    rd_chk(5'h06, 16'h0000, "R1");
    rd_chk(5'h08, 16'h0801, "R1");
    rd_chk(5'h12, 16'h0004, "R1");
    chk("R1", {15'd0, irq}, 16'd0);
    chk("R1", {15'd0, rst_req}, 16'd0);

    // R3 halted counter ignores ticks
    for (int k = 0; k < 5; k++) step(1'b0, 5'h00, 16'h0, 2'b00, 1'b1);
    rd_chk(5'h00, 16'h0004, "R3");

    // R5 rejected field values 0..3, upper bits still stored
    init_model = 16'h0004;
    for (int v = 0; v < 4; v++) begin
      d = {6'(v + 21), 10'(v)};
      step(1'b1, 5'h12, d, 2'b11, 1'b0);
      init_model = init_rule(init_model, d, 2'b11);
      rd_chk(5'h12, init_model, "R5");
    end
    // R10 partial byte writes to the initial-value register
    step(1'b1, 5'h12, 16'h0002, 2'b01, 1'b0);
    init_model = init_rule(init_model, 16'h0002, 2'b01);
    rd_chk(5'h12, init_model, "R10");
    step(1'b1, 5'h12, 16'hFC01, 2'b10, 1'b0);
    init_model = init_rule(init_model, 16'hFC01, 2'b10);
    rd_chk(5'h12, init_model, "R10");

    // two-stage sweep over initial values and both no-reboot settings
    for (int i = 0; i < 6; i++) begin
      logic nr;
      nr = i[0];
      n  = (i < 5) ? 4 + 3 * i : 1023;
      step(1'b1, 5'h08, {4'b0000, 1'b1, 10'd0, nr}, 2'b11, 1'b0);
      step(1'b1, 5'h12, 16'(n), 2'b11, 1'b0);
      rd_chk(5'h12, 16'(n), "R5");
      step(1'b1, 5'h00, 16'h0, 2'b11, 1'b0);
      rd_chk(5'h00, 16'(n), "R4");
      step(1'b1, 5'h08, {15'd0, nr}, 2'b11, 1'b0);
      rd_chk(5'h08, {15'd0, nr}, "R3");
      for (int k = 1; k <= n; k++) begin
        step(1'b0, 5'h00, 16'h0, 2'b00, 1'b1);
        if (k == n || n < 32) rd_chk(5'h00, 16'(n - k), "R2");
      end
      step(1'b0, 5'h00, 16'h0, 2'b00, 1'b1);
      chk("R6", {15'd0, irq}, 16'd1);
      chk("R6", {15'd0, rst_req}, 16'd0);
      rd_chk(5'h00, 16'(n), "R6");
      rd_chk(5'h04, 16'h0008, "R6");
      step(1'b0, 5'h00, 16'h0, 2'b00, 1'b0);
      chk("R6", {15'd0, irq}, 16'd0);
      for (int k = 1; k <= n; k++) step(1'b0, 5'h00, 16'h0, 2'b00, 1'b1);
      rd_chk(5'h00, 16'h0000, "R2");
      step(1'b0, 5'h00, 16'h0, 2'b00, 1'b1);
      chk(nr ? "R8" : "R7", {15'd0, rst_req}, {15'd0, !nr});
      chk("R7", {15'd0, irq}, 16'd0);
      rd_chk(5'h06, 16'h0006, "R7");
      rd_chk(5'h04, 16'h0008, "R7");
      rd_chk(5'h00, 16'(n), "R7");
      step(1'b0, 5'h00, 16'h0, 2'b00, 1'b0);
      chk("R7", {15'd0, rst_req}, 16'd0);
      // R9 write-one-to-clear, R10 disabled byte
      step(1'b1, 5'h04, 16'h0000, 2'b01, 1'b0);
      rd_chk(5'h04, 16'h0008, "R9");
      step(1'b1, 5'h04, 16'h0008, 2'b00, 1'b0);
      rd_chk(5'h04, 16'h0008, "R10");
      step(1'b1, 5'h04, 16'h0008, 2'b01, 1'b0);
      rd_chk(5'h04, 16'h0000, "R9");
      step(1'b1, 5'h06, 16'h0002, 2'b01, 1'b0);
      rd_chk(5'h06, 16'h0004, "R9");
      step(1'b1, 5'h06, 16'h0004, 2'b01, 1'b0);
      rd_chk(5'h06, 16'h0000, "R9");
    end

    // R4 reload beats a same-cycle tick
    step(1'b1, 5'h08, 16'h0801, 2'b11, 1'b0);
    step(1'b1, 5'h12, 16'd6, 2'b11, 1'b0);
    step(1'b1, 5'h00, 16'h0, 2'b01, 1'b0);
    step(1'b1, 5'h08, 16'h0001, 2'b11, 1'b0);
    step(1'b0, 5'h00, 16'h0, 2'b00, 1'b1);
    step(1'b0, 5'h00, 16'h0, 2'b00, 1'b1);
    rd_chk(5'h00, 16'd4, "R2");
    step(1'b1, 5'h00, 16'h0, 2'b10, 1'b1);
    rd_chk(5'h00, 16'd6, "R4");

    // R9 expiry set wins over same-cycle clear
    for (int k = 0; k < 6; k++) step(1'b0, 5'h00, 16'h0, 2'b00, 1'b1);
    rd_chk(5'h00, 16'd0, "R2");
    step(1'b1, 5'h04, 16'h0008, 2'b01, 1'b1);
    chk("R9", {15'd0, irq}, 16'd1);
    rd_chk(5'h04, 16'h0008, "R9");

    // R4 reload on the tick that would expire: no expiry
    for (int k = 0; k < 6; k++) step(1'b0, 5'h00, 16'h0, 2'b00, 1'b1);
    rd_chk(5'h00, 16'd0, "R4");
    step(1'b1, 5'h00, 16'h0, 2'b11, 1'b1);
    chk("R4", {14'd0, irq, rst_req}, 16'd0);
    rd_chk(5'h06, 16'h0000, "R4");
    rd_chk(5'h00, 16'd6, "R4");

    // R10 control byte enables, R3 halt via high byte only
    step(1'b1, 5'h08, 16'h0000, 2'b01, 1'b0);
    rd_chk(5'h08, 16'h0000, "R10");
    step(1'b1, 5'h08, 16'h0801, 2'b10, 1'b0);
    rd_chk(5'h08, 16'h0800, "R10");
    for (int k = 0; k < 3; k++) step(1'b0, 5'h00, 16'h0, 2'b00, 1'b1);
    rd_chk(5'h00, 16'd6, "R3");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule